// File: doc/BRIEF.md
# Half-Duplex Command/Response Serial Controller

This block is the controller side of a synchronous serial link that works in two phases, although transmit and receive have separate lines. On a start request it selects the device, shifts out a fixed 8-bit command on its output line, and then clocks in the device's answer on its input line. The answer is one start bit, which must be zero, followed by a payload whose length the host gives with the request. The length can be any value from 4 to 16 bits.

The host gives the command byte and the payload length together with a one-cycle start strobe. When the frame completes, the controller returns the payload right-aligned, a flag that is set when the start bit arrived as one, and a one-cycle done pulse. A request with a payload length the link cannot carry is refused with an error pulse, and no frame is sent. The serial clock idles low and comes from the system clock through a programmable half-period.

Top module: `hdx_cmd_link`

## Requirements
- R1: After a synchronous active-low reset the outputs are: cs_n = 1, sclk = 0, sdo = 0, busy = 0, done = 0, len_err = 0, start_err = 0 and rsp_data = 0.
- R2: While idle, a start with len in 4..16 is accepted on that clock edge. From the next cycle cs_n = 0 and busy = 1, and sdo already carries bit 7 of cmd.
- R3: Each serial bit cell has sclk low for HALF system cycles and then high for HALF system cycles. sclk pulses only while cs_n is low, and sdo changes only at the start of a cell, so it is stable at every rising sclk edge.
- R4: The command goes out on sdo over the first 8 cells, most significant bit first.
- R5: After the command there is one start-bit cell and then len payload cells, so each frame has exactly 9 + len rising sclk edges. sdi is sampled on each rising sclk edge. The first payload bit received is the MSB. rsp_data[len-1:0] holds the payload and the upper bits of rsp_data are zero.
- R6: sdo is held at 0 during the start-bit cell and all payload cells.
- R7: If the sdi value sampled in the start-bit cell is 1, start_err = 1 when the frame completes, and the payload is still captured. A start bit of 0 gives start_err = 0.
- R8: cs_n stays low across all cells and rises at the clock edge that ends the last payload cell. In that same cycle done is high for exactly one cycle and busy falls.
- R9: A start while idle with len outside 4..16 (for example 0, 3, 17 or 31) gives a one-cycle len_err pulse. cs_n stays high and sclk does not toggle.
- R10: A start asserted while busy is ignored, and the running frame completes with its original command and length.
- R11: rsp_data and start_err keep their values until the next done, including across rejected requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run a frame |
| cmd | input | 8 | Command byte sampled with start |
| len | input | 5 | Payload length in bits, sampled with start |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when a frame completes |
| rsp_data | output | 16 | Received payload, right-aligned |
| start_err | output | 1 | Start bit of the last frame was 1 |
| len_err | output | 1 | One-cycle pulse: request refused for bad length |
| cs_n | output | 1 | Active-low device select |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data to device |
| sdi | input | 1 | Serial data from device |

## Verification
Two cases are hard to reach from the ports. The first is a start bit that arrives as one. The second is a new request that lands in the middle of a frame. The bench holds a device model that follows sclk edge by edge: it collects the command, checks that sdo stays quiet, and then plays back a start-bit value and payload chosen for each frame. This lets a faulty start bit be injected at will. A driver option raises start again, with a different command and length, twenty cycles into a running frame. The scoreboard then requires that the frame's command, edge count and payload are exactly those of the original request.

// File: rtl/hdx_pkg.sv
// Shared types for the half-duplex command/response controller.
// Assumes: nothing beyond IEEE 1800-2017.
package hdx_pkg;
    // Frame phases of the controller sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_SYNC = 2'd2,
        ST_DATA = 2'd3
    } hdx_state_e;
endpackage

// File: rtl/hdx_bit_timer.sv
// Serial clock generator. While run is high it produces an idle-low
// clock whose low and high halves each last HALF system cycles, plus
// single-cycle ticks marking the rising and falling edges.
// Assumes: HALF >= 1; run low returns the clock to its idle state.
module hdx_bit_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          at_end;

    assign at_end    = run && (cnt == CW'(HALF - 1));
    assign rise_tick = at_end && !sclk;
    assign fall_tick = at_end && sclk;

    // Count half periods and flip the serial clock at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (at_end) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hdx_tx_shift.sv
// Parallel-in, serial-out register that presents its MSB first.
// Zeros are shifted in behind the data.
// Assumes: load has priority over shift.
module hdx_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sreg;

    assign msb = sreg[W-1];

    // Hold, load or advance the outgoing word.
    always_ff @(posedge clk) begin
        if (!rst_n)     sreg <= '0;
        else if (load)  sreg <= din;
        else if (shift) sreg <= {sreg[W-2:0], 1'b0};
    end
endmodule

// File: rtl/hdx_rx_shift.sv
// Serial-in, parallel-out register. Each enabled bit enters at the LSB,
// so after n bits the word is right-aligned with its first bit at n-1.
// Assumes: clear has priority over a sample.
module hdx_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    // Collect incoming bits from the LSB side.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (clear)  q <= '0;
        else if (en)     q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/hdx_cmd_link.sv
// Half-duplex command/response serial controller (top).
// A valid request selects the device, sends CMD_BITS command bits MSB
// first, samples one start bit, then samples len payload bits. The
// output line is driven low during the reply. cs_n is released at the
// edge that ends the last payload cell, together with a done pulse.
// Assumes: the device changes sdi only while sclk is low.
module hdx_cmd_link #(
    parameter int CMD_BITS = 8,
    parameter int MIN_LEN  = 4,
    parameter int MAX_LEN  = 16,
    parameter int HALF     = 2,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CMD_BITS-1:0] cmd,
    input  logic [LEN_W-1:0]    len,
    output logic                busy,
    output logic                done,
    output logic [MAX_LEN-1:0]  rsp_data,
    output logic                start_err,
    output logic                len_err,
    output logic                cs_n,
    output logic                sclk,
    output logic                sdo,
    input  logic                sdi
);
    import hdx_pkg::*;

    localparam int SPAN  = (MAX_LEN > CMD_BITS) ? MAX_LEN : CMD_BITS;
    localparam int CNT_W = $clog2(SPAN + 1);

    hdx_state_e          state;
    logic [CNT_W-1:0]    bitcnt;
    logic [LEN_W-1:0]    len_q;
    logic                sync_bit;
    logic                len_ok;
    logic                accept;
    logic                rise_tick;
    logic                fall_tick;
    logic                tx_msb;
    logic [MAX_LEN-1:0]  rx_q;

    assign len_ok = (len >= LEN_W'(MIN_LEN)) && (len <= LEN_W'(MAX_LEN));
    assign accept = (state == ST_IDLE) && start && len_ok;
    assign busy   = (state != ST_IDLE);
    assign sdo    = (state == ST_CMD) && tx_msb;

    hdx_bit_timer #(.HALF(HALF)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .sclk      (sclk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    hdx_tx_shift #(.W(CMD_BITS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .din   (cmd),
        .shift ((state == ST_CMD) && fall_tick),
        .msb   (tx_msb)
    );

    hdx_rx_shift #(.W(MAX_LEN)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .en    ((state == ST_DATA) && rise_tick),
        .din   (sdi),
        .q     (rx_q)
    );

    // Frame sequencer: phases, bit counting, select and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cs_n      <= 1'b1;
            bitcnt    <= '0;
            len_q     <= '0;
            sync_bit  <= 1'b0;
            done      <= 1'b0;
            len_err   <= 1'b0;
            rsp_data  <= '0;
            start_err <= 1'b0;
        end else begin
            done    <= 1'b0;
            len_err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start && len_ok) begin
                        state  <= ST_CMD;
                        cs_n   <= 1'b0;
                        bitcnt <= '0;
                        len_q  <= len;
                    end else if (start) begin
                        len_err <= 1'b1;
                    end
                end
                ST_CMD: begin
                    if (fall_tick) begin
                        if (bitcnt == CNT_W'(CMD_BITS - 1)) begin
                            state  <= ST_SYNC;
                            bitcnt <= '0;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_SYNC: begin
                    if (rise_tick) sync_bit <= sdi;
                    if (fall_tick) state <= ST_DATA;
                end
                ST_DATA: begin
                    if (fall_tick) begin
                        if (bitcnt == CNT_W'(len_q - LEN_W'(1))) begin
                            state     <= ST_IDLE;
                            cs_n      <= 1'b1;
                            done      <= 1'b1;
                            rsp_data  <= rx_q;
                            start_err <= sync_bit;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hdx_cmd_link_chk.sv
// Property checker for hdx_cmd_link, attached by bind below.
// Assumes: the synchronous active-low reset of the checked block.
module hdx_cmd_link_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic len_err,
    input logic cs_n,
    input logic sclk,
    input logic sdo
);
    // R1 / R6: with the device deselected the lines rest low.
    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sclk && !sdo));

    // R8: select is active exactly while a frame runs.
    assert_select_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !cs_n);

    // R8: done lasts one cycle.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done coincides with the release of select.
    assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n)));

    // R9: a refused request leaves the device deselected.
    assert_len_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (cs_n && !busy));

    // R3: the clock only pulses inside a frame.
    assert_sclk_framed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> !cs_n);

    // R3: data out is steady across every rising clock edge.
    assert_sdo_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(sdo));

    // R8 / R9: completion and refusal never overlap.
    assert_excl_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, len_err}));
endmodule

bind hdx_cmd_link hdx_cmd_link_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .len_err (len_err),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .sdo     (sdo)
);

// File: tb/tb_hdx_cmd_link.sv
// Scoreboard bench for hdx_cmd_link: the driver queues expected frames,
// a device model answers on the serial lines, the monitor checks results.
module tb_hdx_cmd_link;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cmd = '0;
    logic [4:0]  len = '0;
    logic        busy, done, start_err, len_err, cs_n, sclk, sdo;
    logic [15:0] rsp_data;
    logic        sdi = 1'b0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0]  cmd;
        logic [15:0] data;
        logic        serr;
        int          edges;
    } exp_t;
    exp_t exp_q[$];

    // device model state
    int          edges = 0;
    logic [7:0]  dev_cmd = '0;
    logic        dev_sb = 1'b0;
    logic [15:0] dev_pay = '0;
    int          dev_len = 4;
    int          sdo_bad = 0;

    // monitor state
    int   run = 0;
    int   cell_bad = 0;
    logic prev_sclk = 1'b0;
    logic prev_cs = 1'b1;

    hdx_cmd_link dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .len(len),
        .busy(busy), .done(done), .rsp_data(rsp_data), .start_err(start_err),
        .len_err(len_err), .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .sdi(sdi)
    );

    always #10 clk = ~clk;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Device: new frame on select.
    always @(negedge cs_n) begin
        edges = 0;
        dev_cmd = '0;
        sdo_bad = 0;
    end

    // Device: capture command, watch the quiet reply phase (R4, R6).
    always @(posedge sclk) begin
        if (!cs_n) begin
            if (edges < 8) dev_cmd = {dev_cmd[6:0], sdo};
            else if (sdo !== 1'b0) sdo_bad++;
            edges++;
        end
    end

    // Device: drive start bit then payload MSB first while sclk is low.
    always @(negedge sclk) begin
        if (!cs_n) begin
            if (edges == 8) sdi = dev_sb;
            else if (edges > 8 && edges < 9 + dev_len) sdi = dev_pay[dev_len - 1 - (edges - 9)];
        end
    end

    // Monitor: cell timing and scoreboard comparison on done.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n) begin
                if (!prev_cs && sclk === prev_sclk) run++;
                else begin
                    if (!prev_cs && run != HALF) cell_bad++;
                    run = 1;
                end
            end else if (!prev_cs) begin
                if (run != HALF) cell_bad++;
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(dev_cmd == e.cmd, "R4", "command bits", dev_cmd, e.cmd);
                    chk(rsp_data == e.data, "R5", "payload", rsp_data, e.data);
                    chk(edges == e.edges, "R5", "rising edge count", edges, e.edges);
                    chk(start_err == e.serr, "R7", "start_err", start_err, e.serr);
                    chk(sdo_bad == 0, "R6", "sdo high in reply", sdo_bad, 0);
                    chk(cell_bad == 0, "R3", "cell half length", cell_bad, 0);
                    chk(cs_n && !busy, "R8", "release with done", {cs_n, busy}, 2'b10);
                end
            end
        end
        prev_sclk = sclk;
        prev_cs = cs_n;
    end

    task automatic xfer(input logic [7:0] c, input int n, input logic [15:0] pay,
                        input logic sb, input bit poke);
        exp_t e;
        e.cmd = c;
        e.data = pay & 16'((32'h1 << n) - 1);
        e.serr = sb;
        e.edges = 9 + n;
        exp_q.push_back(e);
        dev_sb = sb;
        dev_pay = pay;
        dev_len = n;
        @(negedge clk);
        start = 1'b1; cmd = c; len = 5'(n);
        @(negedge clk);
        start = 1'b0;
        chk(!cs_n && busy, "R2", "select after start", {cs_n, busy}, 2'b01);
        chk(sdo == c[7], "R2", "first command bit", sdo, c[7]);
        if (poke) begin
            // R10: a second request mid-frame must be ignored.
            repeat (20) @(negedge clk);
            start = 1'b1; cmd = ~c; len = 5'd4;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic bad_len(input logic [4:0] n);
        logic [15:0] keep_d;
        logic        keep_e;
        keep_d = rsp_data;
        keep_e = start_err;
        @(negedge clk);
        start = 1'b1; cmd = 8'hFF; len = n;
        @(negedge clk);
        start = 1'b0;
        chk(len_err == 1'b1, "R9", "len_err pulse", len_err, 1);
        chk(cs_n && !busy, "R9", "no frame on bad len", {cs_n, busy}, 2'b10);
        @(negedge clk);
        chk(len_err == 1'b0, "R9", "len_err one cycle", len_err, 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!cs_n || sclk) chk(1'b0, "R9", "lines moved", {cs_n, sclk}, 2'b10);
        end
        chk(rsp_data == keep_d && start_err == keep_e, "R11", "result held",
            {start_err, rsp_data}, {keep_e, keep_d});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(cs_n === 1'b1 && sclk === 1'b0 && sdo === 1'b0, "R1", "idle lines",
            {cs_n, sclk, sdo}, 3'b100);
        chk(busy === 1'b0 && done === 1'b0 && len_err === 1'b0, "R1", "idle flags",
            {busy, done, len_err}, 0);
        chk(rsp_data === 16'h0 && start_err === 1'b0, "R1", "idle result",
            {start_err, rsp_data}, 0);

        xfer(8'hA5, 8,  16'h003C, 1'b0, 0);
        xfer(8'h5A, 4,  16'hFFF9, 1'b0, 0);   // R5 upper bits masked
        xfer(8'h81, 16, 16'hBEEF, 1'b0, 0);
        xfer(8'hC3, 13, 16'h1ABC, 1'b1, 0);   // R7 bad start bit
        bad_len(5'd3);                        // R11 holds start_err=1
        xfer(8'h00, 5,  16'h0015, 1'b0, 0);
        xfer(8'h7E, 11, 16'h0555, 1'b0, 1);   // R10 start while busy
        bad_len(5'd17);
        bad_len(5'd0);
        bad_len(5'd31);
        xfer(8'hFF, 4,  16'h000A, 1'b1, 0);
        xfer(8'h3C, 16, 16'h8001, 1'b0, 0);

        // R11: result steady while idle
        begin
            logic [15:0] d0;
            d0 = rsp_data;
            repeat (15) @(negedge clk);
            chk(rsp_data == d0 && done == 1'b0, "R11", "idle hold", rsp_data, d0);
        end
        chk(exp_q.size() == 0, "R8", "frames left unfinished", exp_q.size(), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule